// File: doc/BRIEF.md
# Per-Pin External Interrupt Detector

This block watches up to 32 port pins and raises a per-pin flag when the pin's chosen trigger condition is met. Each pin has a 4-bit trigger code that selects one of six behaviours: off, level high, level low, rising edge, falling edge, or either edge. Pin levels are first brought into the clock domain by a synchronizer chain. A flag can be set only while the module enable is high and the pin's mux selection is a digital one.

Flags stay set until software writes a one to the matching bit of the clear vector. A single interrupt request output is high whenever any flag is set. Register decoding and pad behaviour belong to neighbouring logic. That logic supplies the trigger codes, the mux codes, the enable and the clear pulses as plain inputs.

Top module: `pin_irq_detect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every flag reads 0 and `irq` reads 0.
- R2: Trigger codes are 0 = off, 8 = level low, 9 = rising, 10 = falling, 11 = either edge, 12 = level high. Every other code acts as off and never sets a flag.
- R3: The pin level passes through two synchronizer flops. A pin change sampled at clock edge t is compared with the previous synchronized level and sets the flag at edge t+2 when the edge mode matches: rising for code 9, falling for code 10, either for code 11.
- R4: In a level mode (codes 8 and 12) the flag is set on every edge at which the synchronized level matches. While that level persists, a clear cannot bring the flag to 0.
- R5: A set flag stays set until edge t, where `flag_clr` bit i is 1 in the cycle before edge t. A clear bit of 0 changes nothing. After an edge-mode flag is cleared, a steady pin level does not set it again.
- R6: If a new detection and a clear for the same pin fall in the same cycle, the flag ends up set.
- R7: A flag can be set only when `mod_en` is 1 and the pin's 3-bit mux code is not 0. Mux code 0 means analog or disabled.
- R8: Dropping `mod_en`, moving a pin to mux code 0, or changing its trigger code leaves flags that are already set unchanged.
- R9: `irq` is 1 exactly when at least one flag is 1.
- R10: Pins are independent: stimulus, configuration or a clear on one pin never changes the flag of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; 0 blocks all new detections |
| pin_raw | input | NUM_PINS | Unsynchronized pin levels |
| trig_cfg | input | 4*NUM_PINS | Trigger code per pin; pin i uses bits [4i+3:4i] |
| mux_sel | input | MUX_W*NUM_PINS | Mux code per pin; pin i uses bits [MUX_W*i+MUX_W-1:MUX_W*i] |
| flag_clr | input | NUM_PINS | Write-one-to-clear pulses, one bit per pin |
| flag | output | NUM_PINS | Sticky per-pin interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
Some internal faults leave the flags wrong but the interrupt request correct, so the flags and the request are each compared with the model on every clock. A synchronizer or history register that holds a wrong level shows up as a flag that is set one cycle early, set one cycle late, or missing, in the third cycle after the pin toggle. A wrong trigger decode or enable gate shows up as a flag that appears where the model has none, often many cycles before any clear is issued. A corrupted flag register shows up as a mismatch on the next clock, either through the flag vector or through `irq`.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int TRIG_W = 4;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_OFF  = 4'd0,
        TRIG_LOW  = 4'd8,
        TRIG_RISE = 4'd9,
        TRIG_FALL = 4'd10,
        TRIG_BOTH = 4'd11,
        TRIG_HIGH = 4'd12
    } trig_e;

    // True when the code is one of the defined non-off triggers
    function automatic logic trig_legal(input logic [TRIG_W-1:0] code);
        case (code)
            TRIG_LOW, TRIG_RISE, TRIG_FALL, TRIG_BOTH, TRIG_HIGH: trig_legal = 1'b1;
            default:                                              trig_legal = 1'b0;
        endcase
    endfunction

    // Trigger match for one pin given current and previous synchronized level
    function automatic logic trig_match(input logic [TRIG_W-1:0] code,
                                        input logic cur, input logic prv);
        case (code)
            TRIG_LOW:  trig_match = ~cur;
            TRIG_HIGH: trig_match = cur;
            TRIG_RISE: trig_match = cur & ~prv;
            TRIG_FALL: trig_match = ~cur & prv;
            TRIG_BOTH: trig_match = cur ^ prv;
            default:   trig_match = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] lvl_cur,
    output logic [NUM_PINS-1:0] lvl_prv
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_PINS-1:0] chain;
        logic [NUM_PINS-1:0]                  hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_raw;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.hist = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_cur = st_q.chain[LAST];
    assign lvl_prv = st_q.hist;

    // R3: the history register carries the synchronized level one cycle late
    p_hist_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lvl_prv == $past(lvl_cur));

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int MUX_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mod_en,
    input  logic [NUM_PINS*TRIG_W-1:0]   trig_cfg,
    input  logic [NUM_PINS*MUX_W-1:0]    mux_sel,
    input  logic [NUM_PINS-1:0]          lvl_cur,
    input  logic [NUM_PINS-1:0]          lvl_prv,
    output logic [NUM_PINS-1:0]          hit
);

    logic [NUM_PINS-1:0] live;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [TRIG_W-1:0] code;
        logic [MUX_W-1:0]  mux;

        assign code = trig_cfg[i*TRIG_W +: TRIG_W];
        assign mux  = mux_sel[i*MUX_W +: MUX_W];

        always_comb begin
            live[i] = mod_en & (mux != '0);
            hit[i]  = live[i] & trig_match(code, lvl_cur[i], lvl_prv[i]);
        end

        // R2: undefined codes never produce a detection
        p_undef_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_legal(code) |-> !hit[i]);

        // R3: a rising-mode detection needs a low-to-high step in the synchronized level
        p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (code == TRIG_RISE && hit[i]) |-> (lvl_cur[i] && !lvl_prv[i]));

        // R3: a falling-mode detection needs a high-to-low step
        p_fall_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (code == TRIG_FALL && hit[i]) |-> (!lvl_cur[i] && lvl_prv[i]));
    end

endmodule

// File: rtl/pinirq_flags.sv
module pinirq_flags #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [NUM_PINS-1:0] flag_clr,
    output logic [NUM_PINS-1:0] flag,
    output logic                irq
);

    typedef struct packed {
        logic [NUM_PINS-1:0] bits;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (hit[i])           st_d.bits[i] = 1'b1;
            else if (flag_clr[i]) st_d.bits[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.bits;
    assign irq  = |st_q.bits;

    // R1: flags are clear during reset
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> flag == '0);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R5: a flag only drops after a clear request
        p_drop_needs_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[i]) |-> $past(flag_clr[i]));

        // R6: a detection beats a coincident clear
        p_set_beats_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && flag_clr[i]) |=> flag[i]);

        // R5: without a clear a set flag persists
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !flag_clr[i]) |=> flag[i]);
    end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int MUX_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mod_en,
    input  logic [NUM_PINS-1:0]        pin_raw,
    input  logic [NUM_PINS*TRIG_W-1:0] trig_cfg,
    input  logic [NUM_PINS*MUX_W-1:0]  mux_sel,
    input  logic [NUM_PINS-1:0]        flag_clr,
    output logic [NUM_PINS-1:0]        flag,
    output logic                       irq
);

    logic [NUM_PINS-1:0] lvl_cur;
    logic [NUM_PINS-1:0] lvl_prv;
    logic [NUM_PINS-1:0] hit;

    pinirq_sync #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_raw),
        .lvl_cur (lvl_cur),
        .lvl_prv (lvl_prv)
    );

    pinirq_detect #(
        .NUM_PINS (NUM_PINS),
        .MUX_W    (MUX_W)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (mod_en),
        .trig_cfg (trig_cfg),
        .mux_sel  (mux_sel),
        .lvl_cur  (lvl_cur),
        .lvl_prv  (lvl_prv),
        .hit      (hit)
    );

    pinirq_flags #(
        .NUM_PINS (NUM_PINS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flag_clr (flag_clr),
        .flag     (flag),
        .irq      (irq)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_gate_chk
        // R7: a new flag needs the module enabled and a digital mux code in the prior cycle
        p_gated_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> ($past(mod_en) && $past(mux_sel[i*MUX_W +: MUX_W]) != '0));
    end

    // R9: the request tracks the flag vector
    p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag != '0));

endmodule

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;
    localparam int N  = 32;
    localparam int MW = 3;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_en = 1'b0;
    logic [N-1:0]  pins = '0;
    logic [N*TW-1:0] cfg = '0;
    logic [N*MW-1:0] mux = '0;
    logic [N-1:0]  clr = '0;
    logic [N-1:0]  flag;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pin_irq_detect #(.NUM_PINS(N), .MUX_W(MW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .pin_raw(pins),
        .trig_cfg(cfg), .mux_sel(mux), .flag_clr(clr), .flag(flag), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [N-1:0] m_flag = '0;
    logic [N-1:0] hist[$] = '{'0, '0, '0};

    function automatic bit rule(input int code, input bit c, input bit p);
        if (code == 8)  return !c;
        if (code == 12) return c;
        if (code == 9)  return c && !p;
        if (code == 10) return !c && p;
        if (code == 11) return c != p;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0;
            hist   = '{'0, '0, '0};
        end else begin
            logic [N-1:0] cur, prv;
            cur = hist[1];
            prv = hist[0];
            for (int i = 0; i < N; i++) begin
                bit on, h;
                on = mod_en && (mux[i*MW +: MW] != 0);
                h  = on && rule(int'(cfg[i*TW +: TW]), cur[i], prv[i]);
                if (h) m_flag[i] = 1'b1;
                else if (clr[i]) m_flag[i] = 1'b0;
            end
            hist.push_back(pins);
            void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(flag == m_flag, "R10 flags vs model", 64'(flag), 64'(m_flag));
            chk(irq == (m_flag != 0), "R9 irq vs model", 64'(irq), 64'(m_flag != 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_trig(input int p, input logic [3:0] code);
        cfg[p*TW +: TW] = code;
    endtask

    task automatic clear(input logic [N-1:0] m);
        clr = m;
        cyc(1);
        clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        chk(flag == '0, "R1 flags in reset", 64'(flag), 0);
        chk(irq == 1'b0, "R1 irq in reset", 64'(irq), 0);
        rst_n = 1'b1;
        cyc(1);
        chk(flag == '0, "R1 flags after reset", 64'(flag), 0);

        mod_en = 1'b1;
        for (int i = 0; i < N; i++) mux[i*MW +: MW] = 3'd1;
        cyc(3);
        chk(flag == '0, "R2 code 0 is off", 64'(flag), 0);

        // rising on pin 0
        set_trig(0, 4'd9);
        cyc(1);
        pins[0] = 1'b1;
        cyc(2);
        chk(flag[0] == 1'b0, "R3 not before edge t+2", 64'(flag[0]), 0);
        cyc(1);
        chk(flag[0] == 1'b1, "R3 rising sets", 64'(flag[0]), 1);
        chk(irq == 1'b1, "R9 irq with one flag", 64'(irq), 1);
        clear(32'h0000_0002);
        chk(flag[0] == 1'b1, "R5 clear of other bit ignored", 64'(flag[0]), 1);
        clear(32'h0000_0001);
        chk(flag[0] == 1'b0, "R5 clear drops edge flag", 64'(flag[0]), 0);
        cyc(3);
        chk(flag[0] == 1'b0, "R5 steady level does not re-set", 64'(flag[0]), 0);
        chk(irq == 1'b0, "R9 irq low with no flags", 64'(irq), 0);

        // falling on pin 1, both on pin 2
        pins[1] = 1'b1; pins[2] = 1'b0;
        cyc(3);
        set_trig(1, 4'd10);
        set_trig(2, 4'd11);
        cyc(1);
        pins[1] = 1'b0;
        pins[2] = 1'b1;
        cyc(3);
        chk(flag[1] == 1'b1, "R3 falling sets", 64'(flag[1]), 1);
        chk(flag[2] == 1'b1, "R3 both-edge sets on rise", 64'(flag[2]), 1);
        clear(32'h0000_0004);
        pins[2] = 1'b0;
        cyc(3);
        chk(flag[2] == 1'b1, "R3 both-edge sets on fall", 64'(flag[2]), 1);
        clear(32'h0000_0006);

        // level high pin 3, level low pin 4
        set_trig(3, 4'd12);
        pins[3] = 1'b1;
        cyc(3);
        chk(flag[3] == 1'b1, "R4 level high sets", 64'(flag[3]), 1);
        clear(32'h0000_0008);
        chk(flag[3] == 1'b1, "R4 clear cannot hold level flag low", 64'(flag[3]), 1);
        pins[3] = 1'b0;
        cyc(3);
        clear(32'h0000_0008);
        chk(flag[3] == 1'b0, "R4 clear works once level gone", 64'(flag[3]), 0);
        set_trig(4, 4'd8);
        cyc(2);
        chk(flag[4] == 1'b1, "R4 level low sets", 64'(flag[4]), 1);
        set_trig(4, 4'd0);
        clear(32'h0000_0010);

        // set wins over clear in the same cycle (R6)
        set_trig(5, 4'd9);
        cyc(1);
        pins[5] = 1'b1;
        cyc(2);
        clr[5] = 1'b1;
        cyc(1);
        clr[5] = 1'b0;
        chk(flag[5] == 1'b1, "R6 set beats clear", 64'(flag[5]), 1);
        clear(32'h0000_0020);

        // undefined code
        set_trig(6, 4'd5);
        set_trig(7, 4'd15);
        pins[6] = 1'b1; pins[7] = 1'b1;
        cyc(4);
        pins[6] = 1'b0; pins[7] = 1'b0;
        cyc(4);
        chk(flag[7:6] == 2'b00, "R2 undefined codes off", 64'(flag[7:6]), 0);

        // gating: mux 0 and module disable
        set_trig(8, 4'd11);
        mux[8*MW +: MW] = 3'd0;
        pins[8] = 1'b1;
        cyc(4);
        chk(flag[8] == 1'b0, "R7 analog mux blocks", 64'(flag[8]), 0);
        mux[8*MW +: MW] = 3'd2;
        mod_en = 1'b0;
        pins[8] = 1'b0;
        cyc(4);
        chk(flag[8] == 1'b0, "R7 module disable blocks", 64'(flag[8]), 0);
        mod_en = 1'b1;
        pins[8] = 1'b1;
        cyc(3);
        chk(flag[8] == 1'b1, "R7 enabled again detects", 64'(flag[8]), 1);

        // retention
        mod_en = 1'b0;
        set_trig(8, 4'd0);
        mux[8*MW +: MW] = 3'd0;
        cyc(4);
        chk(flag[8] == 1'b1, "R8 flag kept after disable", 64'(flag[8]), 1);
        chk(flag[7:0] == 8'h00, "R10 other pins untouched", 64'(flag[7:0]), 0);
        mod_en = 1'b1;
        mux[8*MW +: MW] = 3'd1;
        clear(32'h0000_0100);

        // random phase, checked by the per-clock model comparison
        for (int k = 0; k < 4000; k++) begin
            pins = $urandom;
            clr  = (($urandom % 4) == 0) ? $urandom : '0;
            if (($urandom % 16) == 0) mod_en = ($urandom % 4) != 0;
            if (($urandom % 32) == 0) begin
                for (int i = 0; i < N; i++) begin
                    int r;
                    r = $urandom % 9;
                    cfg[i*TW +: TW] = (r < 6) ? 4'(r + 7) : 4'($urandom);
                    mux[i*MW +: MW] = 3'($urandom);
                end
            end
            cyc(1);
        end
        clr = '0;
        cyc(2);
        finish_run();
    end

endmodule